// File: doc/BRIEF.md
# Descriptor ring pointer manager

This block keeps the bookkeeping for a circular ring of work descriptors that software fills and a processing engine consumes. Software never writes pointers. It writes counts. An add write says how many new descriptors were placed in the ring. A release write says how many completed descriptors software has finished with. From these counts the block keeps an engine fetch index, a queue of posted but unfetched work, a count of fetched but unfinished work, and a count of finished but unreleased work. It also keeps the index of the oldest finished descriptor.

The engine sees a simple interface. `fetch_req` is high when there is work and the block is running, and `fetch_idx` names the ring slot to load. The engine accepts a slot with `fetch_ack` and reports each finished descriptor with a one-cycle `done_pulse`. A width-select register picks the descriptor size. The size limits how large the ring may be: 2^12 entries for wide descriptors and 2^14 for narrow ones. The ring-size register is clamped to that limit when it is written.

Register writes take effect on the clock edge. Reads are combinational from `reg_addr`. Offsets are 12 bits wide.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset the block is stopped, the width select reads 7, the ring size reads 4096, all counts and indices are zero and `fetch_req` is low.
- R2: A write to the ring-size register (offset 0x008) stores the written value, except that 0 is stored as 1 and a value above the current limit is stored as the limit. The register reads back the stored value.
- R3: A ring-size write clears the fetch index, the completed index and all three counts in the same edge.
- R4: A write of N (bits [14:0]) to the add register (offset 0x808) adds N to the queued work. A read of offset 0x808 returns, in bits [14:0], the number of posted descriptors not yet completed.
- R5: `fetch_req` is high exactly when the block is running and queued work is nonzero. Each cycle with `fetch_req` and `fetch_ack` both high issues slot `fetch_idx`, moves one descriptor from queued to in flight, and steps `fetch_idx` by one. The index wraps to 0 when it reaches the ring size.
- R6: Bit 0 of the stop register (offset 0x800) halts fetch requests when 1 and enables them when 0. It reads back and drives `engine_run` low while set.
- R7: A `done_pulse` while work is in flight moves one descriptor from in flight to completed-pending in that cycle. A `done_pulse` with nothing in flight is ignored.
- R8: A write of N to the release register (offset 0x804) removes min(N, pending) from the completed-pending count. The completed index advances by that amount modulo the ring size.
- R9: A release write and an accepted completion in the same cycle both take effect.
- R10: The done-status register (offset 0x00C) returns the completed-pending count in bits [14:0] and the low 13 bits of the completed index in bits [28:16]. All other bits are zero.
- R11: The width-select register (offset 0x100, bits [2:0]) reads back as written. Value 7 (wide descriptors) sets the size limit to 4096. Any other value, including 1 for narrow descriptors, sets it to 16384.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fetch_req | output | 1 | Engine may fetch slot `fetch_idx` |
| fetch_idx | output | 14 | Ring slot to fetch next |
| fetch_ack | input | 1 | Engine takes the offered slot |
| done_pulse | input | 1 | One descriptor finished this cycle |
| engine_run | output | 1 | High while not stopped |

## Verification
The bench sweeps ring sizes 1 to 6 through two full laps, so both the fetch index and the completed index cross the wrap point. A design whose wrap compares off by one would issue a slot equal to the ring size or skip slot 0.

It drives a release write in the same cycle as a completion. A design with an if/else priority would lose one of the two updates and leave the pending count off by one. It also releases more than is pending, which an unguarded subtractor would wrap to a huge count. It sends a completion with nothing in flight, which a careless design would count.

Other cases cover clamping under both width selects, the size-0 case, add and fetch in the same cycle, and a completed index past 8191. The 13-bit status field must show the truncated value there, not a value spilling into the reserved bits.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam logic [11:0] OFS_SIZE = 12'h008;
    localparam logic [11:0] OFS_STAT = 12'h00C;
    localparam logic [11:0] OFS_WSEL = 12'h100;
    localparam logic [11:0] OFS_HALT = 12'h800;
    localparam logic [11:0] OFS_REL  = 12'h804;
    localparam logic [11:0] OFS_ADD  = 12'h808;

    localparam logic [2:0] WSEL_WIDE   = 3'd7;
    localparam logic [2:0] WSEL_NARROW = 3'd1;

    localparam int STAT_CNT_LSB = 0;
    localparam int STAT_CNT_W   = 15;
    localparam int STAT_IDX_LSB = 16;
    localparam int STAT_IDX_W   = 13;
endpackage

// File: rtl/ring_cfg.sv
module ring_cfg
    import ring_pkg::*;
#(
    parameter int SMALL_LOG = 14,
    parameter int LARGE_LOG = 12,
    localparam int SZ_W     = SMALL_LOG + 1,
    localparam int CNT_W    = SMALL_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [11:0]      addr,
    input  logic [31:0]      wdata,
    output logic [SZ_W-1:0]  size,
    output logic [2:0]       wsel,
    output logic             run,
    output logic             size_wr,
    output logic             add_wr,
    output logic             rel_wr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [SZ_W-1:0] LIM_WIDE   = SZ_W'(1 << LARGE_LOG);
    localparam logic [SZ_W-1:0] LIM_NARROW = SZ_W'(1 << SMALL_LOG);

    typedef struct packed {
        logic [SZ_W-1:0] size;
        logic [2:0]      wsel;
        logic            halt;
    } cfg_t;

    cfg_t            st_q, st_d;
    logic [SZ_W-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = (st_q.wsel == WSEL_WIDE) ? LIM_WIDE : LIM_NARROW;
        if (wr_en) begin
            case (addr)
                OFS_SIZE: begin
                    if (wdata == 32'd0)
                        st_d.size = SZ_W'(1);
                    else if (wdata > 32'(lim))
                        st_d.size = lim;
                    else
                        st_d.size = SZ_W'(wdata);
                end
                OFS_WSEL: st_d.wsel = wdata[2:0];
                OFS_HALT: st_d.halt = wdata[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.size <= LIM_WIDE;
            st_q.wsel <= WSEL_WIDE;
            st_q.halt <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign size    = st_q.size;
    assign wsel    = st_q.wsel;
    assign run     = !st_q.halt;
    assign size_wr = wr_en && (addr == OFS_SIZE);
    assign add_wr  = wr_en && (addr == OFS_ADD);
    assign rel_wr  = wr_en && (addr == OFS_REL);
    assign cnt     = wdata[CNT_W-1:0];
endmodule

// File: rtl/ring_track.sv
module ring_track #(
    parameter int SMALL_LOG = 14,
    localparam int IDX_W    = SMALL_LOG,
    localparam int SZ_W     = SMALL_LOG + 1,
    localparam int CNT_W    = SMALL_LOG + 1,
    localparam int SUM_W    = SZ_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SZ_W-1:0]  size,
    input  logic             run,
    input  logic             add_wr,
    input  logic             rel_wr,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fetch_ack,
    input  logic             done_pulse,
    output logic             fetch_req,
    output logic [IDX_W-1:0] fetch_idx,
    output logic [IDX_W-1:0] done_idx,
    output logic [CNT_W-1:0] pending,
    output logic [CNT_W-1:0] outstanding
);
    typedef struct packed {
        logic [CNT_W-1:0] queued;
        logic [CNT_W-1:0] inflight;
        logic [CNT_W-1:0] pending;
        logic [IDX_W-1:0] fptr;
        logic [IDX_W-1:0] dptr;
    } trk_t;

    trk_t             st_q, st_d;
    logic             fire, take;
    logic [CNT_W-1:0] add_amt, rel_amt;
    logic [SZ_W-1:0]  fnext;
    logic [SUM_W-1:0] dsum;

    always_comb begin
        st_d    = st_q;
        fire    = run && (st_q.queued != '0) && fetch_ack;
        take    = done_pulse && (st_q.inflight != '0);
        add_amt = add_wr ? cnt : '0;
        rel_amt = '0;
        if (rel_wr)
            rel_amt = (cnt > st_q.pending) ? st_q.pending : cnt;

        st_d.queued   = st_q.queued + add_amt - CNT_W'(fire);
        st_d.inflight = st_q.inflight + CNT_W'(fire) - CNT_W'(take);
        st_d.pending  = st_q.pending + CNT_W'(take) - rel_amt;

        fnext = SZ_W'(st_q.fptr) + SZ_W'(1);
        if (fire)
            st_d.fptr = (fnext == size) ? '0 : IDX_W'(fnext);

        dsum = SUM_W'(st_q.dptr) + SUM_W'(rel_amt);
        if (dsum >= SUM_W'(size))
            dsum = dsum - SUM_W'(size);
        st_d.dptr = IDX_W'(dsum);

        if (clear)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fetch_req   = run && (st_q.queued != '0);
    assign fetch_idx   = st_q.fptr;
    assign done_idx    = st_q.dptr;
    assign pending     = st_q.pending;
    assign outstanding = st_q.queued + st_q.inflight;
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
    import ring_pkg::*;
#(
    parameter int SMALL_LOG = 14,
    parameter int LARGE_LOG = 12,
    localparam int IDX_W    = SMALL_LOG,
    localparam int SZ_W     = SMALL_LOG + 1,
    localparam int CNT_W    = SMALL_LOG + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [11:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             fetch_req,
    output logic [IDX_W-1:0] fetch_idx,
    input  logic             fetch_ack,
    input  logic             done_pulse,
    output logic             engine_run
);
    logic [SZ_W-1:0]  cfg_size;
    logic [2:0]       cfg_wsel;
    logic             cfg_run, cfg_size_wr, cfg_add_wr, cfg_rel_wr;
    logic [CNT_W-1:0] cfg_cnt;
    logic [IDX_W-1:0] trk_done_idx;
    logic [CNT_W-1:0] trk_pending, trk_outstanding;

    ring_cfg #(.SMALL_LOG(SMALL_LOG), .LARGE_LOG(LARGE_LOG)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .size    (cfg_size),
        .wsel    (cfg_wsel),
        .run     (cfg_run),
        .size_wr (cfg_size_wr),
        .add_wr  (cfg_add_wr),
        .rel_wr  (cfg_rel_wr),
        .cnt     (cfg_cnt)
    );

    ring_track #(.SMALL_LOG(SMALL_LOG)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cfg_size_wr),
        .size        (cfg_size),
        .run         (cfg_run),
        .add_wr      (cfg_add_wr),
        .rel_wr      (cfg_rel_wr),
        .cnt         (cfg_cnt),
        .fetch_ack   (fetch_ack),
        .done_pulse  (done_pulse),
        .fetch_req   (fetch_req),
        .fetch_idx   (fetch_idx),
        .done_idx    (trk_done_idx),
        .pending     (trk_pending),
        .outstanding (trk_outstanding)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_SIZE: reg_rdata = 32'(cfg_size);
            OFS_STAT: begin
                reg_rdata[STAT_CNT_LSB +: STAT_CNT_W] = STAT_CNT_W'(trk_pending);
                reg_rdata[STAT_IDX_LSB +: STAT_IDX_W] = STAT_IDX_W'(trk_done_idx);
            end
            OFS_WSEL: reg_rdata = 32'(cfg_wsel);
            OFS_HALT: reg_rdata = 32'(!cfg_run);
            OFS_ADD:  reg_rdata = 32'(trk_outstanding);
            default:  reg_rdata = '0;
        endcase
    end

    assign engine_run = cfg_run;
endmodule

// File: rtl/ring_ptr_chk.sv
module ring_ptr_chk #(
    parameter int IDX_W = 14,
    parameter int SZ_W  = 15,
    parameter int MAXSZ = 16384
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_req,
    input logic             fetch_ack,
    input logic [IDX_W-1:0] fetch_idx,
    input logic [IDX_W-1:0] done_idx,
    input logic [SZ_W-1:0]  ring_size,
    input logic             size_wr,
    input logic             run,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_rdata
);
    // R5
    fetch_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SZ_W'(fetch_idx) < ring_size);

    // R8
    done_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        SZ_W'(done_idx) < ring_size);

    // R6
    halt_blocks_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !fetch_req);

    // R5
    fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ack && !size_wr) |=>
        (SZ_W'(fetch_idx) == (((SZ_W'($past(fetch_idx)) + SZ_W'(1)) == ring_size) ?
                              SZ_W'(0) : (SZ_W'($past(fetch_idx)) + SZ_W'(1)))));

    // R10
    stat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 12'h00C) |-> (reg_rdata[31:29] == 3'd0 && reg_rdata[15] == 1'b0));

    // R2
    size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_size != '0) && (32'(ring_size) <= MAXSZ));
endmodule

bind ring_ptr_mgr ring_ptr_chk #(
    .IDX_W (SMALL_LOG),
    .SZ_W  (SMALL_LOG + 1),
    .MAXSZ (1 << SMALL_LOG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_req (fetch_req),
    .fetch_ack (fetch_ack),
    .fetch_idx (fetch_idx),
    .done_idx  (trk_done_idx),
    .ring_size (cfg_size),
    .size_wr   (cfg_size_wr),
    .run       (cfg_run),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_ring_ptr_mgr.sv
module sim_ring_ptr_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_req;
    logic [13:0] fetch_idx;
    logic        fetch_ack = 1'b0;
    logic        done_pulse = 1'b0;
    logic        engine_run;

    int tests = 0;
    int fails = 0;
    bit ended = 0;

    localparam logic [11:0] A_SIZE = 12'h008, A_STAT = 12'h00C, A_WSEL = 12'h100;
    localparam logic [11:0] A_HALT = 12'h800, A_REL = 12'h804, A_ADD = 12'h808;

    always #5ns clk = ~clk;

    ring_ptr_mgr u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
        .fetch_idx(fetch_idx), .fetch_ack(fetch_ack), .done_pulse(done_pulse),
        .engine_run(engine_run)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    task automatic pulse_done(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            done_pulse = 1'b1;
        end
        @(negedge clk);
        done_pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1ms;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int ef, ed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_SIZE, v); chk("R1 size", v, 32'd4096);
        rd(A_WSEL, v); chk("R1 wsel", v, 32'd7);
        rd(A_HALT, v); chk("R1 halt", v, 32'd1);
        rd(A_STAT, v); chk("R1 status", v, 32'd0);
        rd(A_ADD, v);  chk("R1 outstanding", v, 32'd0);
        chk("R1 fetch_req", 32'(fetch_req), 32'd0);
        chk("R1 engine_run", 32'(engine_run), 32'd0);

        wr(A_HALT, 32'd0);
        chk("R6 run after clear", 32'(engine_run), 32'd1);

        // Sweep of small ring sizes, two laps each: R5 R7 R8 R4 R3
        for (int sz = 1; sz <= 6; sz++) begin
            wr(A_SIZE, sz);
            rd(A_SIZE, v); chk("R2 size readback", v, 32'(sz));
            ef = 0; ed = 0;
            for (int lap = 0; lap < 2; lap++) begin
                wr(A_ADD, sz);
                for (int j = 0; j < sz; j++) begin
                    @(negedge clk);
                    chk("R5 req", 32'(fetch_req), 32'd1);
                    chk("R5 idx", 32'(fetch_idx), 32'(ef));
                    fetch_ack = 1'b1;
                    ef = (ef + 1) % sz;
                end
                @(negedge clk);
                fetch_ack = 1'b0;
                chk("R5 req drops", 32'(fetch_req), 32'd0);
                rd(A_ADD, v); chk("R4 outstanding", v, 32'(sz));
                pulse_done(sz);
                rd(A_STAT, v); chk("R7 status", v, 32'((ed << 16) | sz));
                rd(A_ADD, v);  chk("R7 outstanding", v, 32'd0);
                wr(A_REL, sz - 1);
                ed = (ed + sz - 1) % sz;
                rd(A_STAT, v); chk("R8 partial", v, 32'((ed << 16) | 1));
                wr(A_REL, 1);
                ed = (ed + 1) % sz;
                rd(A_STAT, v); chk("R8 wrap", v, 32'(ed << 16));
            end
        end

        // R6 halt blocks fetch (index now 0 after 12 fetches on size 6)
        wr(A_HALT, 32'd1);
        wr(A_ADD, 32'd2);
        @(negedge clk);
        chk("R6 halted req", 32'(fetch_req), 32'd0);
        rd(A_HALT, v); chk("R6 readback", v, 32'd1);
        wr(A_HALT, 32'd0);
        chk("R6 resumed req", 32'(fetch_req), 32'd1);
        chk("R6 resumed idx", 32'(fetch_idx), 32'd0);
        @(negedge clk); fetch_ack = 1'b1;
        @(negedge clk);
        @(negedge clk); fetch_ack = 1'b0;
        chk("R5 idx after two", 32'(fetch_idx), 32'd2);

        // R9 release and completion in one cycle
        pulse_done(1);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = A_REL; reg_wdata = 32'd1; done_pulse = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; done_pulse = 1'b0;
        rd(A_STAT, v); chk("R9 both applied", v, 32'((1 << 16) | 1));
        rd(A_ADD, v);  chk("R9 outstanding", v, 32'd0);

        // R8 over-release
        wr(A_REL, 32'd5);
        rd(A_STAT, v); chk("R8 over-release", v, 32'(2 << 16));

        // R7 completion with nothing in flight
        pulse_done(1);
        rd(A_STAT, v); chk("R7 ignored", v, 32'(2 << 16));
        rd(A_ADD, v);  chk("R7 ignored outstanding", v, 32'd0);

        // R4 R5 add in the cycle of a fetch
        wr(A_ADD, 32'd1);
        @(negedge clk);
        fetch_ack = 1'b1; reg_wr_en = 1'b1; reg_addr = A_ADD; reg_wdata = 32'd3;
        @(negedge clk);
        fetch_ack = 1'b0; reg_wr_en = 1'b0;
        rd(A_ADD, v); chk("R4 add with fetch", v, 32'd4);
        chk("R5 idx after add", 32'(fetch_idx), 32'd3);

        // R3 size write clears state
        wr(A_SIZE, 32'd6);
        rd(A_ADD, v);  chk("R3 outstanding cleared", v, 32'd0);
        rd(A_STAT, v); chk("R3 status cleared", v, 32'd0);
        chk("R3 idx cleared", 32'(fetch_idx), 32'd0);
        chk("R3 req cleared", 32'(fetch_req), 32'd0);

        // R10 R11 completed index beyond 13 bits on a narrow ring
        wr(A_WSEL, 32'd1);
        rd(A_WSEL, v); chk("R11 wsel readback", v, 32'd1);
        wr(A_SIZE, 32'd16384);
        rd(A_SIZE, v); chk("R11 narrow max", v, 32'd16384);
        wr(A_ADD, 32'd9000);
        @(negedge clk); fetch_ack = 1'b1;
        repeat (9000) @(negedge clk);
        fetch_ack = 1'b0;
        chk("R5 long run idx", 32'(fetch_idx), 32'd9000);
        pulse_done(9000);
        rd(A_STAT, v); chk("R10 pending field", v, 32'd9000);
        wr(A_REL, 32'd9000);
        rd(A_STAT, v); chk("R10 index field", v, 32'(808 << 16));

        // R2 R11 clamping
        wr(A_SIZE, 32'd20000);
        rd(A_SIZE, v); chk("R2 narrow clamp", v, 32'd16384);
        wr(A_WSEL, 32'd7);
        wr(A_SIZE, 32'd5000);
        rd(A_SIZE, v); chk("R2 wide clamp", v, 32'd4096);
        wr(A_SIZE, 32'd0);
        rd(A_SIZE, v); chk("R2 zero to one", v, 32'd1);
        wr(A_WSEL, 32'd3);
        wr(A_SIZE, 32'd16385);
        rd(A_SIZE, v); chk("R11 other select", v, 32'd16384);

        finish_run();
    end
endmodule